// File: doc/BRIEF.md
# Byte/Word Bank Access Controller

This block sits between a CPU load/store port and a bus cycle sequencer in front of a 16-bit memory built from two byte-wide banks. The even bank holds bytes at even addresses and sits on data lines D7–D0. The odd bank holds bytes at odd addresses and sits on D15–D8. The CPU asks for a byte or a word at any byte address. The block turns that request into one or two bank-level bus cycles. For each cycle it produces the word address (byte address bits above bit 0), the address bit 0 line `bus_a0` and an active-low odd-bank enable `bus_bhe_n`. It also places each byte on the correct data lane.

A word at an odd byte address crosses a word boundary. The block therefore runs two cycles. The first cycle moves the word's low byte through the odd bank. The second cycle moves the high byte through the even bank at the next address, and that address wraps at the top of the address space. For reads, the block holds the byte from the first cycle and returns the assembled word once, after the second cycle ends. A cycle is requested by holding `bus_req` high and is ended by a one-clock `bus_done` from the sequencer. If `bus_req` stays high in the next clock, a new cycle has begun.

Top module: `bank_access_ctrl`

## Requirements
- R1: A byte at an even address uses one cycle with `bus_a0`=0 and `bus_bhe_n`=1. Write data goes on bits 7:0 and bits 15:8 are zero. Read data is taken from bits 7:0 and returned zero-extended.
- R2: A byte at an odd address uses one cycle with `bus_a0`=1 and `bus_bhe_n`=0. Write data goes on bits 15:8 and bits 7:0 are zero. Read data is taken from bits 15:8 and returned zero-extended.
- R3: A word at an even address uses exactly one cycle with `bus_a0`=0 and `bus_bhe_n`=0. The low byte is on bits 7:0 and the high byte is on bits 15:8.
- R4: A word at an odd address uses exactly two cycles.
- R5: The first cycle of an odd-address word uses word address `addr>>1`, `bus_a0`=1 and `bus_bhe_n`=0. The word's low byte is on bits 15:8 and bits 7:0 are zero.
- R6: The second cycle uses byte address `addr+1`, modulo 2^ADDR_W, split into word address and `bus_a0`=0, with `bus_bhe_n`=1. The word's high byte is on bits 7:0 and bits 15:8 are zero.
- R7: An odd-address word read returns {second cycle bits 7:0, first cycle bits 15:8}.
- R8: `cpu_done` is a single-clock pulse. It is high in the clock after the final `bus_done`, and `cpu_busy` is low in that clock.
- R9: `cpu_start` is ignored while `cpu_busy` is high. It changes neither the cycles in flight nor what follows them.
- R10: After reset the block is idle, with `cpu_busy`, `bus_req` and `cpu_done` low.
- R11: `bus_wr` equals the request's write flag during every cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | Request strobe, taken when idle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = word, 0 = byte |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 16 | Write data (byte in bits 7:0) |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | Request finished pulse |
| cpu_rdata | output | 16 | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus cycle requested |
| bus_wr | output | 1 | Cycle direction |
| bus_waddr | output | ADDR_W-1 | Word address |
| bus_a0 | output | 1 | Address bit 0, low enables even bank |
| bus_bhe_n | output | 1 | Low enables odd bank |
| bus_wdata | output | 16 | Write data lanes |
| bus_done | input | 1 | Current cycle finished |
| bus_rdata | input | 16 | Read data lanes, valid with bus_done |

## Verification
The bench builds the block with its default ADDR_W of 20, so the full 20-bit space is present. The topmost odd byte, 0xFFFFF, can be driven directly to show the second-cycle address wrapping to word 0. A sequencer model inserts a chosen number of wait clocks before each `bus_done`. This shows that lane routing, the held low byte and the single completion pulse do not depend on how long each cycle stalls.

// File: rtl/bank_access_ctrl.sv
module bank_access_ctrl #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_start,
  input  logic              cpu_write,
  input  logic              cpu_word,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [15:0]       cpu_rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-2:0] bus_waddr,
  output logic              bus_a0,
  output logic              bus_bhe_n,
  output logic [15:0]       bus_wdata,
  input  logic              bus_done,
  input  logic [15:0]       bus_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t            state;
  logic              op_wr, op_word;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_wdata;
  logic [7:0]        lo_hold;
  logic              done_q;
  logic [15:0]       rdata_q;

  logic              second, odd, split;
  logic [ADDR_W-1:0] cur_addr;
  logic [15:0]       rd_final;

  assign second   = (state == S_SECOND);
  assign odd      = op_addr[0];
  assign split    = op_word & odd;
  assign cur_addr = second ? op_addr + ADDR_W'(1) : op_addr;

  assign cpu_busy  = (state != S_IDLE);
  assign bus_req   = cpu_busy;
  assign bus_wr    = op_wr;
  assign bus_waddr = cur_addr[ADDR_W-1:1];
  assign bus_a0    = cur_addr[0];
  assign bus_bhe_n = second ? 1'b1 : ~(odd | op_word);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_comb begin
    if (second)       bus_wdata = {8'h00, op_wdata[15:8]};
    else if (odd)     bus_wdata = {op_wdata[7:0], 8'h00};
    else if (op_word) bus_wdata = op_wdata;
    else              bus_wdata = {8'h00, op_wdata[7:0]};
  end

  always_comb begin
    if (second)       rd_final = {bus_rdata[7:0], lo_hold};
    else if (odd)     rd_final = {8'h00, bus_rdata[15:8]};
    else if (op_word) rd_final = bus_rdata;
    else              rd_final = {8'h00, bus_rdata[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_wr    <= 1'b0;
      op_word  <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      lo_hold  <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (cpu_start) begin
          op_wr    <= cpu_write;
          op_word  <= cpu_word;
          op_addr  <= cpu_addr;
          op_wdata <= cpu_wdata;
          state    <= S_FIRST;
        end
        S_FIRST: if (bus_done) begin
          if (split) begin
            lo_hold <= bus_rdata[15:8];
            state   <= S_SECOND;
          end else begin
            if (!op_wr) rdata_q <= rd_final;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_SECOND: if (bus_done) begin
          if (!op_wr) rdata_q <= rd_final;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bank_access_ctrl_chk.sv
module bank_access_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_done,
  input logic              bus_wr,
  input logic              bus_a0,
  input logic              bus_bhe_n,
  input logic [ADDR_W-2:0] bus_waddr,
  input logic [15:0]       bus_wdata
);

  a_r10_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !cpu_busy |-> !bus_req);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_busy);

  a_r2_some_bank_on: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !(bus_a0 && bus_bhe_n));

  a_r6_second_even: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req) && $past(bus_done)) |-> (!bus_a0 && bus_bhe_n));

  a_r11_cycle_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_waddr) && $stable(bus_a0)
                                && $stable(bus_bhe_n) && $stable(bus_wr)));

  a_r1_upper_lane_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_bhe_n) |-> (bus_wdata[15:8] == 8'h00));

  a_r5_lower_lane_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_a0) |-> (bus_wdata[7:0] == 8'h00));

endmodule

bind bank_access_ctrl bank_access_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_done(bus_done), .bus_wr(bus_wr), .bus_a0(bus_a0),
  .bus_bhe_n(bus_bhe_n), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata)
);

// File: tb/tb_bank_access_ctrl.sv
`timescale 1ns/1ps
module tb_bank_access_ctrl;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_start = 0, cpu_write = 0, cpu_word = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_busy, cpu_done;
  logic [15:0] cpu_rdata;
  logic bus_req, bus_wr, bus_a0, bus_bhe_n;
  logic [AW-2:0] bus_waddr;
  logic [15:0] bus_wdata;
  logic bus_done = 0;
  logic [15:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  bank_access_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cpu_start(cpu_start), .cpu_write(cpu_write),
    .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_a0(bus_a0),
    .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  int ncyc, gap, got;
  logic [AW-2:0] c_wa [4];
  logic c_a0 [4], c_bhe [4], c_wr [4];
  logic [15:0] c_wd [4];
  logic [15:0] rd_res;
  logic busy_at_done;

  function automatic logic [15:0] mdl(input logic [AW-2:0] w);
    return {w[7:0] ^ 8'hC3, w[7:0] + 8'h21};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic wd, input logic [AW-1:0] a,
                        input logic [15:0] wdv, input int waits, input bit inject);
    int wc, last_t;
    wc = 0; last_t = 0; ncyc = 0; got = 0; gap = 0;
    @(negedge clk);
    cpu_start = 1; cpu_write = wr; cpu_word = wd; cpu_addr = a; cpu_wdata = wdv;
    for (int t = 0; t < 60 && got == 0; t++) begin
      @(negedge clk);
      bus_done = 0;
      cpu_start = 0;
      if (cpu_done) begin
        got = 1; rd_res = cpu_rdata; busy_at_done = cpu_busy; gap = t - last_t;
      end else if (bus_req) begin
        if (inject && t == 0) begin
          cpu_start = 1; cpu_write = 0; cpu_word = 0; cpu_addr = '0;
        end
        if (wc == waits) begin
          if (ncyc < 4) begin
            c_wa[ncyc] = bus_waddr; c_a0[ncyc] = bus_a0; c_bhe[ncyc] = bus_bhe_n;
            c_wr[ncyc] = bus_wr; c_wd[ncyc] = bus_wdata;
          end
          bus_rdata = mdl(bus_waddr);
          bus_done = 1; ncyc++; last_t = t; wc = 0;
        end else wc++;
      end
    end
    chk("R8 done seen", 32'(got), 32'd1);
    chk("R8 done one clock after last bus_done", 32'(gap), 32'd1);
    chk("R8 busy low with done", 32'(busy_at_done), 32'd0);
    @(negedge clk);
    chk("R8 done single pulse", 32'(cpu_done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R10 busy after reset", 32'(cpu_busy), 0);
    chk("R10 req after reset", 32'(bus_req), 0);
    chk("R10 done after reset", 32'(cpu_done), 0);
  endtask

  task automatic t_byte_even;
    run_op(1, 0, 20'h00A42, 16'hBE5A, 0, 0);
    chk("R1 cycles", 32'(ncyc), 1);
    chk("R1 waddr", 32'(c_wa[0]), 32'h00521);
    chk("R1 a0", 32'(c_a0[0]), 0);
    chk("R1 bhe_n", 32'(c_bhe[0]), 1);
    chk("R1 wdata", 32'(c_wd[0]), 32'h005A);
    chk("R11 wr", 32'(c_wr[0]), 1);
    run_op(0, 0, 20'h00A42, 16'h0, 1, 0);
    chk("R1 read", 32'(rd_res), 32'({8'h00, mdl(19'h00521)[7:0]}));
    chk("R11 rd dir", 32'(c_wr[0]), 0);
  endtask

  task automatic t_byte_odd;
    run_op(1, 0, 20'h31007, 16'h11C7, 0, 0);
    chk("R2 cycles", 32'(ncyc), 1);
    chk("R2 waddr", 32'(c_wa[0]), 32'h18803);
    chk("R2 a0", 32'(c_a0[0]), 1);
    chk("R2 bhe_n", 32'(c_bhe[0]), 0);
    chk("R2 wdata", 32'(c_wd[0]), 32'hC700);
    run_op(0, 0, 20'h31007, 16'h0, 2, 0);
    chk("R2 read", 32'(rd_res), 32'({8'h00, mdl(19'h18803)[15:8]}));
  endtask

  task automatic t_word_even;
    run_op(1, 1, 20'h7FF10, 16'hA1B2, 1, 0);
    chk("R3 cycles", 32'(ncyc), 1);
    chk("R3 a0", 32'(c_a0[0]), 0);
    chk("R3 bhe_n", 32'(c_bhe[0]), 0);
    chk("R3 wdata", 32'(c_wd[0]), 32'hA1B2);
    run_op(0, 1, 20'h7FF10, 16'h0, 0, 0);
    chk("R3 read", 32'(rd_res), 32'(mdl(19'h3FF88)));
  endtask

  task automatic t_word_odd_write;
    run_op(1, 1, 20'h01235, 16'h9C4D, 1, 0);
    chk("R4 cycles", 32'(ncyc), 2);
    chk("R5 waddr", 32'(c_wa[0]), 32'h0091A);
    chk("R5 a0", 32'(c_a0[0]), 1);
    chk("R5 bhe_n", 32'(c_bhe[0]), 0);
    chk("R5 wdata", 32'(c_wd[0]), 32'h4D00);
    chk("R6 waddr", 32'(c_wa[1]), 32'h0091B);
    chk("R6 a0", 32'(c_a0[1]), 0);
    chk("R6 bhe_n", 32'(c_bhe[1]), 1);
    chk("R6 wdata", 32'(c_wd[1]), 32'h009C);
    chk("R11 wr both", 32'({c_wr[0], c_wr[1]}), 32'b11);
  endtask

  task automatic t_word_odd_read;
    run_op(0, 1, 20'h01235, 16'h0, 2, 0);
    chk("R4 read cycles", 32'(ncyc), 2);
    chk("R7 read word", 32'(rd_res),
        32'({mdl(19'h0091B)[7:0], mdl(19'h0091A)[15:8]}));
    chk("R11 rd both", 32'({c_wr[0], c_wr[1]}), 0);
  endtask

  task automatic t_wrap;
    run_op(1, 1, 20'hFFFFF, 16'h3377, 0, 0);
    chk("R6 wrap c1 waddr", 32'(c_wa[0]), 32'h7FFFF);
    chk("R6 wrap c2 waddr", 32'(c_wa[1]), 0);
    chk("R6 wrap c2 a0", 32'(c_a0[1]), 0);
    run_op(0, 1, 20'hFFFFF, 16'h0, 1, 0);
    chk("R7 wrap read", 32'(rd_res), 32'({mdl(19'h0)[7:0], mdl(19'h7FFFF)[15:8]}));
  endtask

  task automatic t_busy_ignore;
    run_op(1, 1, 20'h40003, 16'h6655, 2, 1);
    chk("R9 cycles", 32'(ncyc), 2);
    chk("R9 c1 waddr", 32'(c_wa[0]), 32'h20001);
    chk("R9 c2 waddr", 32'(c_wa[1]), 32'h20002);
    chk("R9 c2 wdata", 32'(c_wd[1]), 32'h0066);
    @(negedge clk);
    chk("R9 no extra busy", 32'(cpu_busy), 0);
    chk("R9 no extra req", 32'(bus_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_byte_even();
    t_byte_odd();
    t_word_even();
    t_word_odd_write();
    t_word_odd_read();
    t_wrap();
    t_busy_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule